// File: doc/BRIEF.md
# Receive Character Buffer with Overrun Marking

This block stores received characters between a serial receive stage and the host. A character that arrives on a byte-valid input first lands in a single holding register. It moves on into an eight-entry data FIFO as soon as there is room. A status FIFO runs beside the data FIFO and holds one status word per character. The host sees the head character and its status at all times, and removes it with a one-cycle pop strobe.

When a character arrives while the FIFO and the holding register are both occupied, the block discards the new character. It then sets an overrun bit in the status of the character waiting in the holding register. That character is still good data. When it reaches the FIFO head it raises an exception request, not a data request, so the host learns where the stream broke.

The data request asserts when FIFO occupancy reaches a programmable threshold and the head character is clean. The exception request asserts for any head character with a nonzero status. A single enable input gates both requests. A count output reports every character the block holds.

Top module: `rxbuf_top`

## Requirements
- R1: After reset, rxCount is 0, outValid is 0, and both dataReq and excReq are 0.
- R2: An accepted character is in the holding register after one clock edge and at the FIFO head after the next edge, if the FIFO has room. Characters leave in arrival order. outStatus bits [2:0] carry the inErr value given with the character. Bit 3 is the overrun mark.
- R3: rxCount equals the FIFO occupancy plus 1 when the holding register is occupied. It never exceeds 9.
- R4: An arriving character is lost only when the FIFO holds 8 entries, the holding register is occupied, and no pop occurs in that cycle. A pop in the same cycle lets the held character move into the FIFO and lets the new character enter the holding register.
- R5: On overrun the new character is discarded. The held character keeps its data and gets status bit 3 set. Further arrivals while storage stays full are also discarded.
- R6: When the overrun-marked character reaches the FIFO head, excReq is 1 and dataReq is 0 until the host pops it.
- R7: dataReq is 1 when enabled, the FIFO occupancy is at least the threshold, and the head status is zero. A threshold of 0 acts as 1, and a threshold above 8 acts as 8.
- R8: excReq is 1 exactly when enabled, the FIFO is non-empty and the head status is nonzero. dataReq and excReq are never both 1.
- R9: With rxEnable at 0, both requests are 0. Stored characters stay in place and are not affected.
- R10: A pop while the FIFO is empty has no effect on the count or the order of later characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | New character present this cycle |
| inData | input | 8 | Received character |
| inErr | input | 3 | Line error bits for the character |
| rxEnable | input | 1 | Enables both service requests |
| threshold | input | 4 | FIFO occupancy at which dataReq asserts |
| popReq | input | 1 | Removes the head character |
| outData | output | 8 | Head character |
| outStatus | output | 4 | Head status: [2:0] line errors, [3] overrun |
| outValid | output | 1 | FIFO holds at least one character |
| dataReq | output | 1 | Data service request |
| excReq | output | 1 | Exception service request |
| rxCount | output | 4 | Characters held in FIFO plus holding register |

## Verification
Two events can fall in the same cycle: a host pop and the arrival of a new character while both storage stages are full. Whether the arrival counts as an overrun depends on their order within that cycle. The bench fills all nine places, then drives inValid and popReq together. The arrival must not be lost: rxCount stays at 9, and draining returns every character in order with clean status. In a second case the arrival comes without a pop. It must be dropped, and the overrun mark must show up on the previously held character.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam int ERR_W  = 3;
  localparam int STAT_W = ERR_W + 1;
  localparam int OVR_BIT = ERR_W;

  typedef struct packed {
    logic loadHold;
    logic moveHold;
    logic popFifo;
    logic tagOverrun;
  } rxStrobes_t;
endpackage

// File: rtl/rxbuf_datapath.sv
module rxbuf_datapath
  import rxbuf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FCNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobes_t        strobes,
  input  logic [DATA_W-1:0] inData,
  input  logic [ERR_W-1:0]  inErr,
  output logic              holdValid,
  output logic [FCNT_W-1:0] fifoCount,
  output logic [DATA_W-1:0] headData,
  output logic [STAT_W-1:0] headStatus
);
  logic [DATA_W-1:0] holdData;
  logic [STAT_W-1:0] holdStatus;
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [STAT_W-1:0] statMem [DEPTH];

  // holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid  <= 1'b0;
      holdData   <= '0;
      holdStatus <= '0;
    end else if (strobes.loadHold) begin
      holdValid  <= 1'b1;
      holdData   <= inData;
      holdStatus <= {1'b0, inErr};
    end else begin
      if (strobes.moveHold)   holdValid <= 1'b0;
      if (strobes.tagOverrun) holdStatus[OVR_BIT] <= 1'b1;
    end
  end

  // data and status FIFO entries, one slot per generate iteration
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataMem[i] <= '0;
        statMem[i] <= '0;
      end else if (strobes.moveHold && wrPtr == PTR_W'(i)) begin
        dataMem[i] <= holdData;
        statMem[i] <= holdStatus;
      end
    end
  end

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else begin
      if (strobes.moveHold) wrPtr <= nextPtr(wrPtr);
      if (strobes.popFifo)  rdPtr <= nextPtr(rdPtr);
      fifoCount <= fifoCount + FCNT_W'(strobes.moveHold) - FCNT_W'(strobes.popFifo);
    end
  end

  assign headData   = dataMem[rdPtr];
  assign headStatus = (fifoCount != '0) ? statMem[rdPtr] : '0;
endmodule

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int FCNT_W = $clog2(DEPTH + 1)
) (
  input  logic              inValid,
  input  logic              popReq,
  input  logic              rxEnable,
  input  logic [FCNT_W-1:0] threshold,
  input  logic              holdValid,
  input  logic [FCNT_W-1:0] fifoCount,
  input  logic [STAT_W-1:0] headStatus,
  output rxStrobes_t        strobes,
  output logic              dataReq,
  output logic              excReq
);
  logic              fifoEmpty;
  logic              fifoRoom;
  logic              headBad;
  logic [FCNT_W-1:0] effThr;

  always_comb begin
    fifoEmpty = (fifoCount == '0);
    strobes.popFifo    = popReq && !fifoEmpty;
    fifoRoom           = (fifoCount < FCNT_W'(DEPTH)) || strobes.popFifo;
    strobes.moveHold   = holdValid && fifoRoom;
    strobes.loadHold   = inValid && (!holdValid || strobes.moveHold);
    strobes.tagOverrun = inValid && holdValid && !strobes.moveHold;
  end

  always_comb begin
    if (threshold == '0)                 effThr = FCNT_W'(1);
    else if (threshold > FCNT_W'(DEPTH)) effThr = FCNT_W'(DEPTH);
    else                                 effThr = threshold;
    headBad = !fifoEmpty && (headStatus != '0);
    excReq  = rxEnable && headBad;
    dataReq = rxEnable && !fifoEmpty && !headBad && (fifoCount >= effThr);
  end
endmodule

// File: rtl/rxbuf_top.sv
module rxbuf_top
  import rxbuf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int FCNT_W = $clog2(DEPTH + 1),
  localparam int CNT_W  = $clog2(DEPTH + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic [ERR_W-1:0]  inErr,
  input  logic              rxEnable,
  input  logic [FCNT_W-1:0] threshold,
  input  logic              popReq,
  output logic [DATA_W-1:0] outData,
  output logic [STAT_W-1:0] outStatus,
  output logic              outValid,
  output logic              dataReq,
  output logic              excReq,
  output logic [CNT_W-1:0]  rxCount
);
  rxStrobes_t        strobes;
  logic              holdValid;
  logic [FCNT_W-1:0] fifoCount;
  logic [STAT_W-1:0] headStatus;

  rxbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .inValid(inValid), .popReq(popReq), .rxEnable(rxEnable),
    .threshold(threshold), .holdValid(holdValid), .fifoCount(fifoCount),
    .headStatus(headStatus), .strobes(strobes), .dataReq(dataReq), .excReq(excReq)
  );

  rxbuf_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inData(inData), .inErr(inErr),
    .holdValid(holdValid), .fifoCount(fifoCount), .headData(outData),
    .headStatus(headStatus)
  );

  assign outStatus = headStatus;
  assign outValid  = (fifoCount != '0);
  assign rxCount   = CNT_W'(fifoCount) + CNT_W'(holdValid);
endmodule

// File: rtl/rxbuf_checker.sv
module rxbuf_checker #(
  parameter int DEPTH = 8,
  parameter int STAT_W = 4,
  parameter int CNT_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              popReq,
  input logic              rxEnable,
  input logic              dataReq,
  input logic              excReq,
  input logic              outValid,
  input logic [STAT_W-1:0] outStatus,
  input logic [CNT_W-1:0]  rxCount
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH + 1);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= FULL); // R3
  AST_NO_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !popReq && rxCount < FULL) |=> rxCount == $past(rxCount) + 1'b1); // R4
  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && popReq && rxCount == FULL) |=> rxCount == FULL); // R4
  AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !popReq && rxCount == FULL) |=> rxCount == FULL); // R5
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(dataReq && excReq)); // R6
  AST_EXC_HEAD: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> (outValid && outStatus != '0)); // R8
  AST_EXC_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && outValid && outStatus != '0) |-> excReq); // R8
  AST_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |-> (!dataReq && !excReq)); // R9
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !inValid && rxCount == '0) |=> rxCount == '0); // R10
endmodule

bind rxbuf_top rxbuf_checker #(.DEPTH(DEPTH), .STAT_W(rxbuf_pkg::STAT_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .popReq(popReq), .rxEnable(rxEnable),
  .dataReq(dataReq), .excReq(excReq), .outValid(outValid), .outStatus(outStatus),
  .rxCount(rxCount)
);

// File: tb/rxbuf_top_tb.sv
module rxbuf_top_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inData = '0;
  logic [2:0] inErr = '0;
  logic       rxEnable = 1'b1;
  logic [3:0] threshold = 4'd8;
  logic       popReq = 1'b0;
  logic [7:0] outData;
  logic [3:0] outStatus;
  logic       outValid, dataReq, excReq;
  logic [3:0] rxCount;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxbuf_top u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inErr(inErr),
    .rxEnable(rxEnable), .threshold(threshold), .popReq(popReq),
    .outData(outData), .outStatus(outStatus), .outValid(outValid),
    .dataReq(dataReq), .excReq(excReq), .rxCount(rxCount)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pushChar(logic [7:0] d, logic [2:0] e);
    inValid = 1'b1; inData = d; inErr = e;
    @(negedge clk);
    inValid = 1'b0; inErr = '0;
  endtask

  task automatic popOne();
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    chk("R1", "rxCount", rxCount, 0);
    chk("R1", "outValid", outValid, 0);
    chk("R1", "dataReq", dataReq, 0);
    chk("R1", "excReq", excReq, 0);
  endtask

  task automatic testOrder();
    threshold = 4'd8;
    pushChar(8'hA1, 3'b000);
    chk("R2", "in hold outValid", outValid, 0);
    chk("R3", "hold count", rxCount, 1);
    idle(1);
    chk("R2", "head valid", outValid, 1);
    chk("R2", "head data", outData, 8'hA1);
    pushChar(8'hB2, 3'b010);
    pushChar(8'hC3, 3'b000);
    idle(1);
    chk("R3", "three held", rxCount, 3);
    chk("R7", "below threshold", dataReq, 0);
    popOne();
    chk("R2", "second data", outData, 8'hB2);
    chk("R2", "second status", outStatus, 4'b0010);
    chk("R8", "error head excReq", excReq, 1);
    chk("R8", "error head dataReq", dataReq, 0);
    popOne();
    chk("R2", "third data", outData, 8'hC3);
    chk("R2", "third status", outStatus, 0);
    popOne();
    chk("R3", "drained", rxCount, 0);
  endtask

  task automatic testThreshold();
    threshold = 4'd2;
    pushChar(8'h11, 3'b000);
    idle(1);
    chk("R7", "one below two", dataReq, 0);
    pushChar(8'h12, 3'b000);
    idle(1);
    chk("R7", "two reaches two", dataReq, 1);
    popOne();
    threshold = 4'd0;
    @(negedge clk);
    chk("R7", "zero acts as one", dataReq, 1);
    threshold = 4'd15;
    @(negedge clk);
    chk("R7", "above eight clamps", dataReq, 0);
    popOne();
    threshold = 4'd8;
  endtask

  task automatic testOverrun();
    for (int i = 0; i < 9; i++) pushChar(8'h40 + 8'(i), 3'b000);
    chk("R3", "full count", rxCount, 9);
    chk("R7", "full dataReq", dataReq, 1);
    pushChar(8'hEE, 3'b000);
    chk("R5", "drop count", rxCount, 9);
    pushChar(8'hEF, 3'b000);
    chk("R5", "second drop count", rxCount, 9);
    for (int i = 0; i < 8; i++) begin
      chk("R5", "pre-overrun data", outData, 8'h40 + i);
      chk("R5", "pre-overrun status", outStatus, 0);
      popOne();
    end
    chk("R5", "tagged data kept", outData, 8'h48);
    chk("R5", "overrun bit", outStatus, 4'b1000);
    chk("R6", "tagged excReq", excReq, 1);
    chk("R6", "tagged dataReq", dataReq, 0);
    popOne();
    chk("R5", "dropped chars absent", rxCount, 0);
  endtask

  task automatic testSameCycle();
    for (int i = 0; i < 9; i++) pushChar(8'h60 + 8'(i), 3'b000);
    inValid = 1'b1; inData = 8'h7A; popReq = 1'b1;
    @(negedge clk);
    inValid = 1'b0; popReq = 1'b0;
    chk("R4", "pop+arrive count", rxCount, 9);
    for (int i = 1; i < 9; i++) begin
      chk("R4", "order data", outData, 8'h60 + i);
      chk("R4", "no overrun mark", outStatus, 0);
      popOne();
    end
    chk("R4", "new char kept", outData, 8'h7A);
    chk("R4", "new char clean", outStatus, 0);
    popOne();
    chk("R4", "empty after", rxCount, 0);
  endtask

  task automatic testEnable();
    pushChar(8'h55, 3'b100);
    rxEnable = 1'b0;
    idle(1);
    chk("R9", "gated excReq", excReq, 0);
    chk("R9", "gated dataReq", dataReq, 0);
    chk("R9", "storage kept", rxCount, 1);
    rxEnable = 1'b1;
    @(negedge clk);
    chk("R9", "reenabled excReq", excReq, 1);
    chk("R9", "data kept", outData, 8'h55);
    popOne();
  endtask

  task automatic testPopEmpty();
    popOne();
    popOne();
    chk("R10", "count after empty pop", rxCount, 0);
    pushChar(8'h99, 3'b000);
    pushChar(8'h9A, 3'b000);
    idle(1);
    chk("R10", "count after pushes", rxCount, 2);
    chk("R10", "head after empty pop", outData, 8'h99);
    popOne();
    chk("R10", "next after empty pop", outData, 8'h9A);
    popOne();
  endtask

  initial begin
    idle(2);
    testReset();
    rstN = 1'b1;
    idle(1);
    testReset();
    testOrder();
    testThreshold();
    testOverrun();
    testSameCycle();
    testEnable();
    testPopEmpty();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule